// File: doc/BRIEF.md
# Receive Page Ring Manager

This block stores received frames in a circular buffer made of 256-byte pages. The ring runs from a first page up to, but not including, a limit page. After the last page of the ring, writing continues at the first page. The block accepts a byte stream with start-of-frame, end-of-frame and error indications, and drives a byte-wide RAM write port whose address is the page number concatenated with the byte offset.

Each stored frame starts at the current page. The first four bytes of that page are kept free for a header, and frame data begins at offset 4. When the frame ends, the block writes the header into those four bytes: a status byte, the next-page pointer, then the low and high bytes of the frame length. It then moves its current-page pointer to the next-page value and pulses a packet-received flag.

Host software frees space by moving a boundary page register. When a byte would land in the boundary page, the block drops the frame, leaves the current page unchanged and pulses an overwrite-warning flag. Frames that arrive with an error indication are also dropped without a header. Address filtering and the line interface are handled elsewhere.

Top module: `rx_page_ring`

## Requirements
- R1: While reset is asserted, `mem_we`, `pkt_rcvd`, `ovw_warn` and `cur_page` are all zero. A `ring_init` pulse loads `cur_page` with `pg_start` and the boundary register with `pg_stop - 1`.
- R2: The first byte of a frame is written at offset 4 of the current page. Each following byte goes to the next byte address {page, offset}.
- R3: After offset 255 of page `pg_stop - 1`, the next data byte is written at offset 0 of page `pg_start`.
- R4: After the last data byte, four header writes go to offsets 0, 1, 2 and 3 of the frame's first page, one per cycle, in the order status, next page, length low, length high.
- R5: The stored length is the number of bytes in the frame, counting the CRC bytes. Header offset 2 holds bits 7:0 and offset 3 holds bits 15:8.
- R6: The next-page byte is the page after the last page that holds frame data, wrapping from `pg_stop - 1` to `pg_start`. A frame that fills its last page exactly points to the following page.
- R7: In a stored frame's status byte, bit 0 is 1 (received intact), bit 5 equals `rx_mcast` at end of frame, and every other bit is 0.
- R8: `cur_page` takes the next-page value in the same cycle that `pkt_rcvd` is high. `pkt_rcvd` lasts exactly one cycle per stored frame, and `cur_page` changes at no other time except `ring_init`.
- R9: A byte whose target page equals the boundary register is not written. `ovw_warn` pulses for one cycle, the rest of the frame is ignored, no header is written, `pkt_rcvd` stays low and `cur_page` is unchanged.
- R10: A frame whose end byte carries `rx_crc_err`, `rx_align_err` or `rx_fifo_ovr` gets no header and no `pkt_rcvd` pulse, and `cur_page` is unchanged.
- R11: A `bnd_we` pulse loads the boundary register with `bnd_wdata`, which frees pages for later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_init | input | 1 | Loads the current page and boundary from the ring limits |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the ring |
| bnd_we | input | 1 | Boundary register write strobe |
| bnd_wdata | input | 8 | New boundary page |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_crc_err | input | 1 | CRC error, sampled with the end byte |
| rx_align_err | input | 1 | Alignment error, sampled with the end byte |
| rx_fifo_ovr | input | 1 | FIFO overrun, sampled with the end byte |
| rx_mcast | input | 1 | Multicast or broadcast frame, sampled with the end byte |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address {page, offset} |
| mem_wdata | output | 8 | RAM write data |
| cur_page | output | 8 | Current page pointer |
| pkt_rcvd | output | 1 | One-cycle pulse when a frame has been stored |
| ovw_warn | output | 1 | One-cycle pulse when a frame was dropped at the boundary |

## Verification
Each write for an accepted byte appears on the RAM port one cycle after the clock edge that takes the byte. The four header writes follow in the four cycles after the write of the last byte. `pkt_rcvd` and the new `cur_page` appear together with the last header write, and `ovw_warn` appears one cycle after the offending byte. The bench drives inputs on falling edges and mirrors every RAM write into a model memory at the next falling edge. It pops the expected header from its queue at the falling edge where `pkt_rcvd` is seen. Data bytes, `cur_page` and the pulse counts are compared only after ten idle cycles, when every result of the frame is certain to have arrived.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_DROP = 2'd2,
    RX_HDR  = 2'd3
  } rx_state_e;

  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;
  localparam int ST_INTACT = 0;
  localparam int ST_MCAST  = 5;
endpackage

// File: rtl/rxring_ptrs.sv
module rxring_ptrs #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_init,
  input  logic [PAGE_W-1:0] pg_start,
  input  logic [PAGE_W-1:0] pg_stop,
  input  logic              bnd_we,
  input  logic [PAGE_W-1:0] bnd_wdata,
  input  logic              adv,
  input  logic [PAGE_W-1:0] adv_page,
  output logic [PAGE_W-1:0] cur_page,
  output logic [PAGE_W-1:0] bnd_page
);
  logic [PAGE_W-1:0] cur_q, cur_d, bnd_q, bnd_d;
  logic              cur_en, bnd_en;

  always_comb begin
    cur_en = ring_init | adv;
    bnd_en = ring_init | bnd_we;
    cur_d  = ring_init ? pg_start : adv_page;
    bnd_d  = ring_init ? pg_stop - 1'b1 : bnd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      bnd_q <= '0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (bnd_en) bnd_q <= bnd_d;
    end
  end

  assign cur_page = cur_q;
  assign bnd_page = bnd_q;
endmodule

// File: rtl/rxring_wr.sv
module rxring_wr
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ring_init,
  input  logic [PAGE_W-1:0]       pg_start,
  input  logic [PAGE_W-1:0]       pg_stop,
  input  logic [PAGE_W-1:0]       cur_page,
  input  logic [PAGE_W-1:0]       bnd_page,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_crc_err,
  input  logic                    rx_align_err,
  input  logic                    rx_fifo_ovr,
  input  logic                    rx_mcast,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic                    adv,
  output logic [PAGE_W-1:0]       adv_page,
  output logic                    pkt_rcvd,
  output logic                    ovw_warn
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_BYTES);

  function automatic logic [PAGE_W-1:0] pg_wrap(input logic [PAGE_W-1:0] p,
                                                input logic [PAGE_W-1:0] s,
                                                input logic [PAGE_W-1:0] e);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == e) ? s : q;
  endfunction

  rx_state_e         st_q, st_d;
  logic [PAGE_W-1:0] wpg_q, wpg_d, nxt_q, nxt_d;
  logic [OFF_W-1:0]  woff_q, woff_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [7:0]        stat_q, stat_d;
  logic [1:0]        hidx_q, hidx_d;
  logic              we_q, we_d, prx_q, prx_d, ovw_q, ovw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdat_q, wdat_d;

  logic              take, first, bad;
  logic [PAGE_W-1:0] tgt_pg, inc_pg, fin_pg;
  logic [OFF_W-1:0]  tgt_off, inc_off;
  logic [7:0]        hbyte, stat_new;

  always_comb begin
    first   = (st_q == RX_IDLE);
    take    = rx_valid && ((first && rx_sof) || (st_q == RX_DATA));
    tgt_pg  = first ? cur_page : wpg_q;
    tgt_off = first ? DATA_OFF : woff_q;
    inc_off = tgt_off + 1'b1;
    inc_pg  = (inc_off == '0) ? pg_wrap(tgt_pg, pg_start, pg_stop) : tgt_pg;
    fin_pg  = (inc_off == '0) ? inc_pg : pg_wrap(inc_pg, pg_start, pg_stop);
    bad     = rx_crc_err | rx_align_err | rx_fifo_ovr;
    stat_new            = '0;
    stat_new[ST_INTACT] = 1'b1;
    stat_new[ST_MCAST]  = rx_mcast;
    case (hidx_q)
      2'd0:    hbyte = stat_q;
      2'd1:    hbyte = 8'(nxt_q);
      2'd2:    hbyte = len_q[7:0];
      default: hbyte = len_q[15:8];
    endcase
  end

  always_comb begin
    st_d   = st_q;
    wpg_d  = wpg_q;
    woff_d = woff_q;
    len_d  = len_q;
    nxt_d  = nxt_q;
    stat_d = stat_q;
    hidx_d = hidx_q;
    we_d   = 1'b0;
    addr_d = addr_q;
    wdat_d = wdat_q;
    prx_d  = 1'b0;
    ovw_d  = 1'b0;
    adv    = 1'b0;

    if (st_q == RX_DROP && rx_valid && rx_eof) st_d = RX_IDLE;

    if (st_q == RX_HDR) begin
      we_d   = 1'b1;
      addr_d = {cur_page, OFF_W'(hidx_q)};
      wdat_d = hbyte;
      hidx_d = hidx_q + 1'b1;
      if (hidx_q == 2'd3) begin
        st_d  = RX_IDLE;
        adv   = 1'b1;
        prx_d = 1'b1;
      end
    end

    if (take) begin
      if (tgt_pg == bnd_page) begin
        ovw_d = 1'b1;
        st_d  = rx_eof ? RX_IDLE : RX_DROP;
      end else begin
        we_d   = 1'b1;
        addr_d = {tgt_pg, tgt_off};
        wdat_d = rx_data;
        wpg_d  = inc_pg;
        woff_d = inc_off;
        len_d  = first ? LEN_W'(1) : len_q + 1'b1;
        st_d   = RX_DATA;
        if (rx_eof) begin
          st_d   = bad ? RX_IDLE : RX_HDR;
          hidx_d = 2'd0;
          nxt_d  = fin_pg;
          stat_d = stat_new;
        end
      end
    end

    if (ring_init) begin
      st_d  = RX_IDLE;
      we_d  = 1'b0;
      prx_d = 1'b0;
      ovw_d = 1'b0;
      adv   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      wpg_q  <= '0;
      woff_q <= '0;
      len_q  <= '0;
      nxt_q  <= '0;
      stat_q <= '0;
      hidx_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      prx_q  <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      we_q   <= we_d;
      prx_q  <= prx_d;
      ovw_q  <= ovw_d;
      hidx_q <= hidx_d;
      if (take) begin
        wpg_q  <= wpg_d;
        woff_q <= woff_d;
        len_q  <= len_d;
        nxt_q  <= nxt_d;
        stat_q <= stat_d;
      end
      if (we_d) begin
        addr_q <= addr_d;
        wdat_q <= wdat_d;
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign adv_page  = nxt_q;
  assign pkt_rcvd  = prx_q;
  assign ovw_warn  = ovw_q;
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ring_init,
  input  logic [PAGE_W-1:0]       pg_start,
  input  logic [PAGE_W-1:0]       pg_stop,
  input  logic                    bnd_we,
  input  logic [PAGE_W-1:0]       bnd_wdata,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_crc_err,
  input  logic                    rx_align_err,
  input  logic                    rx_fifo_ovr,
  input  logic                    rx_mcast,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       cur_page,
  output logic                    pkt_rcvd,
  output logic                    ovw_warn
);
  logic [PAGE_W-1:0] bnd_page;
  logic [PAGE_W-1:0] adv_page;
  logic              adv;

  rxring_ptrs #(.PAGE_W(PAGE_W)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_init (ring_init),
    .pg_start  (pg_start),
    .pg_stop   (pg_stop),
    .bnd_we    (bnd_we),
    .bnd_wdata (bnd_wdata),
    .adv       (adv),
    .adv_page  (adv_page),
    .cur_page  (cur_page),
    .bnd_page  (bnd_page)
  );

  rxring_wr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ring_init    (ring_init),
    .pg_start     (pg_start),
    .pg_stop      (pg_stop),
    .cur_page     (cur_page),
    .bnd_page     (bnd_page),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .rx_data      (rx_data),
    .rx_crc_err   (rx_crc_err),
    .rx_align_err (rx_align_err),
    .rx_fifo_ovr  (rx_fifo_ovr),
    .rx_mcast     (rx_mcast),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .adv          (adv),
    .adv_page     (adv_page),
    .pkt_rcvd     (pkt_rcvd),
    .ovw_warn     (ovw_warn)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ring_init,
  input logic [PAGE_W-1:0]       pg_start,
  input logic [PAGE_W-1:0]       pg_stop,
  input logic [PAGE_W-1:0]       bnd_page,
  input logic [PAGE_W-1:0]       cur_page,
  input logic                    mem_we,
  input logic [PAGE_W+OFF_W-1:0] mem_addr,
  input logic                    pkt_rcvd,
  input logic                    ovw_warn
);
  logic [PAGE_W-1:0] wr_pg;
  logic [OFF_W-1:0]  wr_off;
  assign wr_pg  = mem_addr[PAGE_W+OFF_W-1:OFF_W];
  assign wr_off = mem_addr[OFF_W-1:0];

  assert_wr_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_pg >= pg_start) && (wr_pg < pg_stop));

  assert_no_bnd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_pg != bnd_page));

  assert_prx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcvd |=> !pkt_rcvd);

  assert_prx_last_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcvd |-> mem_we && (wr_off == OFF_W'(3)) && (wr_pg == $past(cur_page)));

  assert_cur_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ring_init) && !pkt_rcvd) |-> $stable(cur_page));

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_rcvd && ovw_warn));
endmodule

bind rx_page_ring rxring_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_rxring_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ring_init (ring_init),
  .pg_start  (pg_start),
  .pg_stop   (pg_stop),
  .bnd_page  (bnd_page),
  .cur_page  (cur_page),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .pkt_rcvd  (pkt_rcvd),
  .ovw_warn  (ovw_warn)
);

// File: tb/test_rx_page_ring.sv
module test_rx_page_ring;
  localparam int P_START = 16;
  localparam int P_STOP  = 22;

  logic        clk = 1'b0;
  logic        rst_n, ring_init, bnd_we, rx_valid, rx_sof, rx_eof;
  logic        rx_crc_err, rx_align_err, rx_fifo_ovr, rx_mcast;
  logic [7:0]  pg_start, pg_stop, bnd_wdata, rx_data, mem_wdata, cur_page;
  logic [15:0] mem_addr;
  logic        mem_we, pkt_rcvd, ovw_warn;

  always #10 clk = ~clk;

  rx_page_ring i_rx_page_ring (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init),
    .pg_start(pg_start), .pg_stop(pg_stop),
    .bnd_we(bnd_we), .bnd_wdata(bnd_wdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .rx_fifo_ovr(rx_fifo_ovr), .rx_mcast(rx_mcast),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .pkt_rcvd(pkt_rcvd), .ovw_warn(ovw_warn)
  );

  typedef struct {
    int pg;
    int st;
    int nx;
    int ln;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] mem_m [int];
  int n_chk = 0, n_bad = 0, n_prx = 0, n_ovw = 0;
  int b_cur, b_bnd;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    if (mem_m.exists(a)) return int'(mem_m[a]);
    return -1;
  endfunction

  function automatic int nxpg(input int p);
    return (p + 1 == P_STOP) ? P_START : p + 1;
  endfunction

  // monitor: mirror RAM writes, count pulses, score headers
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
      if (ovw_warn) n_ovw++;
      if (pkt_rcvd) begin
        n_prx++;
        if (exp_q.size() == 0) begin
          check("R8 unexpected pkt_rcvd", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check("R7 status byte", rd(e.pg * 256 + 0), e.st);
          check("R6 next-page byte", rd(e.pg * 256 + 1), e.nx);
          check("R5 length low", rd(e.pg * 256 + 2), e.ln & 255);
          check("R5 length high", rd(e.pg * 256 + 3), (e.ln >> 8) & 255);
          check("R8 cur_page with pkt_rcvd", int'(cur_page), e.nx);
        end
      end
    end
  end

  task automatic set_bnd(input int v);
    @(negedge clk);
    bnd_we    = 1'b1;
    bnd_wdata = 8'(v);
    @(negedge clk);
    bnd_we    = 1'b0;
    b_bnd     = v;
  endtask

  // driver: model the frame, push the expected header, then drive bytes
  task automatic send(input string tag, input int n, input int seed, input bit mc,
                      input bit ce, input bit ae, input bit fo);
    int  pg, off, nx, prx0, ovw0, cur0, mism;
    bit  ovf, good;
    int  addrs[$];
    pg = b_cur; off = 4; ovf = 0;
    prx0 = n_prx; ovw0 = n_ovw; cur0 = b_cur;
    for (int i = 0; i < n; i++) begin
      if (pg == b_bnd) begin
        ovf = 1;
        break;
      end
      addrs.push_back(pg * 256 + off);
      off++;
      if (off == 256) begin
        off = 0;
        pg  = nxpg(pg);
      end
    end
    nx   = (off == 0) ? pg : nxpg(pg);
    good = !ovf && !(ce || ae || fo);
    if (good) exp_q.push_back('{b_cur, mc ? 33 : 1, nx, n});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid     = 1'b1;
      rx_sof       = (i == 0);
      rx_eof       = (i == n - 1);
      rx_data      = 8'(seed + i);
      rx_mcast     = (i == n - 1) && mc;
      rx_crc_err   = (i == n - 1) && ce;
      rx_align_err = (i == n - 1) && ae;
      rx_fifo_ovr  = (i == n - 1) && fo;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    rx_mcast = 1'b0; rx_crc_err = 1'b0; rx_align_err = 1'b0; rx_fifo_ovr = 1'b0;
    repeat (10) @(negedge clk);
    if (good) begin
      mism = 0;
      foreach (addrs[j]) if (rd(addrs[j]) != ((seed + j) & 255)) mism++;
      check({tag, " R2 R3 data bytes mismatched"}, mism, 0);
      check({tag, " R8 one pkt_rcvd"}, n_prx - prx0, 1);
      check({tag, " R9 no ovw_warn"}, n_ovw - ovw0, 0);
      b_cur = nx;
    end else begin
      check({tag, " R9 R10 cur_page held"}, int'(cur_page), cur0);
      check({tag, " R9 R10 no pkt_rcvd"}, n_prx - prx0, 0);
      check({tag, " R9 ovw_warn count"}, n_ovw - ovw0, ovf ? 1 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ring_init = 1'b0; bnd_we = 1'b0; bnd_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    rx_crc_err = 1'b0; rx_align_err = 1'b0; rx_fifo_ovr = 1'b0; rx_mcast = 1'b0;
    pg_start = 8'(P_START); pg_stop = 8'(P_STOP);
    repeat (4) @(negedge clk);
    check("R1 reset mem_we", int'(mem_we), 0);
    check("R1 reset pkt_rcvd", int'(pkt_rcvd), 0);
    check("R1 reset ovw_warn", int'(ovw_warn), 0);
    check("R1 reset cur_page", int'(cur_page), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ring_init = 1'b1;
    @(negedge clk);
    ring_init = 1'b0;
    check("R1 init cur_page", int'(cur_page), P_START);
    b_cur = P_START;
    b_bnd = P_STOP - 1;

    send("A short frame R2",      60, 1,   0, 0, 0, 0);
    send("B two-page mcast R7",  300, 9,   1, 0, 0, 0);
    send("C exact page fill R6", 252, 77,  0, 0, 0, 0);
    send("D hits init bnd R1",   300, 5,   0, 0, 0, 0);
    set_bnd(18);
    send("E wrap after bnd R3 R11", 600, 100, 0, 0, 0, 0);
    send("F crc error R10",       80, 3,   0, 1, 0, 0);
    send("F2 fifo overrun R10",   20, 4,   0, 0, 0, 1);
    send("G good after drop R4",  64, 200, 1, 0, 0, 0);
    send("H cur equals bnd R9",   10, 50,  0, 0, 0, 0);

    check("R4 all headers seen", exp_q.size(), 0);
    check("R8 final cur_page", int'(cur_page), 18);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule